// File: doc/BRIEF.md
# Redundant Binary Carry-Free Adder

This block adds two signed-digit numbers of `N_DIGITS` digits each. Every digit takes one of the values -1, 0 or +1 and travels on a two-bit code. The result has `N_DIGITS + 1` digits in the same code. The digit set has redundancy, so each position can settle its own result digit from a short window of neighbouring input digits. No carry ripples across the word, and the delay through the adder does not depend on the width. The cell is the same at every position, so the adder tiles cleanly into an array, for example as one row of a partial-product reduction structure.

Each position forms the digit-pair sum of its two operand digits. It then splits that sum into an outgoing transfer digit and an intermediate digit. When the pair sum is ±1, the split follows a flag from the position below. The flag says whether either operand digit one position lower is negative. Because of this, the transfer that arrives from below can always be absorbed without leaving the digit set. The final digit at a position is the intermediate digit there plus the transfer arriving from below. The transfer out of the top position becomes the extra most significant digit. A parameter selects whether the sum leaves through an output register or directly from the combinational network.

Top module: `rbadd_top`

## Requirements
- R1: Digit i of every operand and of the sum sits at bits [2i+1:2i]. Bit 2i+1 is the sign bit and bit 2i is the magnitude bit. Code 00 means 0, 01 means +1 and 11 means -1.
- R2: The value of the N_DIGITS+1 digit sum equals the value of operand A plus the value of operand B, for any operand digits. The value of a word is the sum over i of digit_i times 2^i.
- R3: Every sum digit carries one of the codes 00, 01 or 11. The code 10 never appears on the output.
- R4: Sum digit i depends only on the operand digits at positions i, i-1 and i-2. Changing the digits at position 0 leaves sum digits 3 and above unchanged.
- R5: With A = +1 at position 0 and B = 0 there, the position sees a clear lower flag. It produces intermediate -1 and transfer +1, so the sum is digit0 = -1 and digit1 = +1. With A = -1 at position 0 and +1 at position 1, and B = 0, position 1 sees a set flag. The sum is then digit0 = -1, digit1 = +1 and digit2 = 0. With A = -1 at positions 0 and 1, the sum is digit0 = -1, digit1 = +1 and digit2 = -1.
- R6: The transfer out of the top position becomes sum digit N_DIGITS. With both operands all +1, the sum is 0 at digit 0 and +1 at digits 1..N_DIGITS. With both operands all -1, it is 0 at digit 0 and -1 at digits 1..N_DIGITS. If both operand digits at the top position are non-negative, sum digit N_DIGITS is never -1.
- R7: An operand digit carrying the unused code 10 is treated as 0. The sum is identical to the sum with 00 in that place.
- R8: With OUT_REG = 1 (the default), the sum appears on `sum_dig` one clock edge after the operands are applied. While `rst_n` is low, `sum_dig` is all zeros. With OUT_REG = 0, `sum_dig` follows the operands combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| a_dig | input | 2*N_DIGITS | Operand A, two bits per digit |
| b_dig | input | 2*N_DIGITS | Operand B, two bits per digit |
| sum_dig | output | 2*(N_DIGITS+1) | Sum, two bits per digit, registered when OUT_REG = 1 |

## Verification
Two events can meet at one position in the same cycle. One is the intermediate digit that the position chose from its own pair. The other is the transfer arriving from the position below. The case that matters is when both are non-zero with the same sign, because that would leave the digit set.

The bench provokes these collisions in several ways:
- directed patterns where a ±1 pair sits just above a negative or a non-negative pair;
- all-+1 and all--1 operands, which force a transfer at every position at once;
- random operands.

Each result is judged in three ways. Its integer value must equal the sum of the operand values. No output digit may carry the code 10. The digit-by-digit pattern must match the hand-derived result for the directed cases.

// File: rtl/rbadd_pkg.sv
package rbadd_pkg;

    typedef logic [1:0] rb_digit_t;

    // R1: digit codes {sign, magnitude}
    localparam rb_digit_t RB_ZERO = 2'b00;
    localparam rb_digit_t RB_POS  = 2'b01;
    localparam rb_digit_t RB_NEG  = 2'b11;

    // Decode a digit to its integer value; the unused code 10 reads as 0 (R7)
    function automatic int rb_val(input rb_digit_t d);
        case (d)
            RB_POS:  return 1;
            RB_NEG:  return -1;
            default: return 0;
        endcase
    endfunction

    // Encode an integer in {-1,0,1} as a digit code
    function automatic rb_digit_t rb_enc(input int v);
        if (v > 0)      return RB_POS;
        else if (v < 0) return RB_NEG;
        else            return RB_ZERO;
    endfunction

    function automatic logic rb_is_neg(input rb_digit_t d);
        return d[1] & d[0];
    endfunction

endpackage

// File: rtl/rbadd_cell.sv
// One digit position: splits the local pair sum into a transfer to the next
// position and an intermediate digit, guided by the flag from below.
module rbadd_cell
    import rbadd_pkg::*;
(
    input  rb_digit_t x_dig,
    input  rb_digit_t y_dig,
    input  logic      lower_neg,   // some operand digit one place lower is negative
    output rb_digit_t xfer_dig,    // transfer into the next position
    output rb_digit_t mid_dig,     // intermediate digit kept here
    output logic      here_neg     // flag handed to the next position
);

    int pair_sum;

    always_comb begin
        pair_sum = rb_val(x_dig) + rb_val(y_dig);
        xfer_dig = RB_ZERO;
        mid_dig  = RB_ZERO;
        case (pair_sum)
            2: begin
                xfer_dig = RB_POS;
                mid_dig  = RB_ZERO;
            end
            -2: begin
                xfer_dig = RB_NEG;
                mid_dig  = RB_ZERO;
            end
            1: begin
                // incoming transfer is >= 0 when lower flag is clear
                if (!lower_neg) begin
                    xfer_dig = RB_POS;
                    mid_dig  = RB_NEG;
                end else begin
                    xfer_dig = RB_ZERO;
                    mid_dig  = RB_POS;
                end
            end
            -1: begin
                // incoming transfer is <= 0 when lower flag is set
                if (!lower_neg) begin
                    xfer_dig = RB_ZERO;
                    mid_dig  = RB_NEG;
                end else begin
                    xfer_dig = RB_NEG;
                    mid_dig  = RB_POS;
                end
            end
            default: begin
                xfer_dig = RB_ZERO;
                mid_dig  = RB_ZERO;
            end
        endcase
        here_neg = rb_is_neg(x_dig) | rb_is_neg(y_dig);
    end

endmodule

// File: rtl/rbadd_merge.sv
// Final digit: intermediate digit plus the transfer from the position below.
module rbadd_merge
    import rbadd_pkg::*;
(
    input  rb_digit_t mid_dig,
    input  rb_digit_t xfer_in,
    output rb_digit_t res_dig
);

    int total;

    always_comb begin
        total   = rb_val(mid_dig) + rb_val(xfer_in);
        res_dig = rb_enc(total);
    end

endmodule

// File: rtl/rbadd_top.sv
module rbadd_top
    import rbadd_pkg::*;
#(
    parameter int N_DIGITS = 16,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2*N_DIGITS-1:0]     a_dig,
    input  logic [2*N_DIGITS-1:0]     b_dig,
    output logic [2*(N_DIGITS+1)-1:0] sum_dig
);

    localparam int SUM_DIGITS = N_DIGITS + 1;
    localparam int SUM_W      = 2 * SUM_DIGITS;

    typedef struct packed {
        logic [SUM_W-1:0] sum;
    } out_state_t;

    rb_digit_t            xfer  [N_DIGITS];
    rb_digit_t            mid   [N_DIGITS];
    rb_digit_t            fin   [N_DIGITS];
    logic [N_DIGITS:0]    neg_chain;
    logic [SUM_W-1:0]     sum_comb;
    out_state_t           st_d, st_q;

    assign neg_chain[0] = 1'b0;   // nothing below position 0

    for (genvar i = 0; i < N_DIGITS; i++) begin : g_pos
        rbadd_cell u_cell (
            .x_dig    (a_dig[2*i+1:2*i]),
            .y_dig    (b_dig[2*i+1:2*i]),
            .lower_neg(neg_chain[i]),
            .xfer_dig (xfer[i]),
            .mid_dig  (mid[i]),
            .here_neg (neg_chain[i+1])
        );
        if (i == 0) begin : g_lsd
            rbadd_merge u_merge (
                .mid_dig(mid[i]),
                .xfer_in(RB_ZERO),
                .res_dig(fin[i])
            );
        end else begin : g_upper
            rbadd_merge u_merge (
                .mid_dig(mid[i]),
                .xfer_in(xfer[i-1]),
                .res_dig(fin[i])
            );
        end
        assign sum_comb[2*i+1:2*i] = fin[i];
    end

    // R6: transfer out of the top position is the extra digit
    assign sum_comb[SUM_W-1:SUM_W-2] = xfer[N_DIGITS-1];

    always_comb begin
        st_d     = st_q;
        st_d.sum = sum_comb;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
        assign sum_dig = st_q.sum;

        p_reset_clear_r8: assert property (@(posedge clk)
            $rose(rst_n) |-> (sum_dig == '0))
            else $error("p_reset_clear_r8");
    end else begin : g_comb
        assign st_q    = st_d;
        assign sum_dig = st_q.sum;
    end

    // ---------------- assertions ----------------
    function automatic longint word_val(input logic [SUM_W-1:0] w, input int nd);
        longint acc;
        acc = 0;
        for (int k = 0; k < nd; k++)
            acc += longint'(rb_val(w[2*k+:2])) * (longint'(1) << k);
        return acc;
    endfunction

    p_sum_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_val(sum_comb, SUM_DIGITS) ==
        word_val({2'b00, a_dig}, N_DIGITS) + word_val({2'b00, b_dig}, N_DIGITS))
        else $error("p_sum_value_r2");

    for (genvar k = 0; k < SUM_DIGITS; k++) begin : g_code_chk
        p_digit_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
            sum_comb[2*k+1:2*k] != 2'b10)
            else $error("p_digit_code_r3");
    end

    p_top_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !neg_chain[N_DIGITS] |-> (sum_comb[SUM_W-1:SUM_W-2] != RB_NEG))
        else $error("p_top_carry_r6");

    p_flag_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_dig[1:0] == RB_POS && b_dig[1:0] == RB_ZERO) |->
        (sum_comb[1:0] == RB_NEG))
        else $error("p_flag_rule_r5");

endmodule

// File: tb/tb_rbadd_top.sv
module tb_rbadd_top;

    localparam int N   = 16;
    localparam int AW  = 2 * N;
    localparam int SW  = 2 * (N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] a_dig = '0;
    logic [AW-1:0] b_dig = '0;
    logic [SW-1:0] sum_dig;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    rbadd_top #(.N_DIGITS(N), .OUT_REG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .a_dig(a_dig), .b_dig(b_dig), .sum_dig(sum_dig)
    );

    function automatic int dval(input logic [1:0] d);
        if (d == 2'b01) return 1;
        if (d == 2'b11) return -1;
        return 0;
    endfunction

    function automatic longint wval(input logic [63:0] w, input int nd);
        longint acc = 0;
        for (int k = 0; k < nd; k++)
            acc += longint'(dval(w[2*k+:2])) * (longint'(1) << k);
        return acc;
    endfunction

    function automatic logic [AW-1:0] rand_word();
        logic [AW-1:0] w;
        for (int k = 0; k < N; k++) begin
            case ($urandom % 3)
                0:       w[2*k+:2] = 2'b00;
                1:       w[2*k+:2] = 2'b01;
                default: w[2*k+:2] = 2'b11;
            endcase
        end
        return w;
    endfunction

    function automatic logic [AW-1:0] fill_word(input logic [1:0] d);
        logic [AW-1:0] w;
        for (int k = 0; k < N; k++) w[2*k+:2] = d;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // apply at negedge, register at posedge, observe at the following negedge
    task automatic apply(input logic [AW-1:0] a, input logic [AW-1:0] b);
        @(negedge clk);
        a_dig = a;
        b_dig = b;
        @(negedge clk);
    endtask

    task automatic check_value(input string req);
        longint exp_v = wval({32'd0, a_dig}, N) + wval({32'd0, b_dig}, N);
        longint act_v = wval({30'd0, sum_dig}, N + 1);
        bit     bad   = 1'b0;
        chk(act_v == exp_v, req, act_v, exp_v);
        for (int k = 0; k <= N; k++)
            if (sum_dig[2*k+:2] == 2'b10) bad = 1'b1;
        chk(!bad, "R3 code", longint'(sum_dig), 0);
    endtask

    task automatic t_reset();
        a_dig = fill_word(2'b01);
        b_dig = fill_word(2'b01);
        repeat (3) @(negedge clk);
        chk(sum_dig == '0, "R8 reset", longint'(sum_dig), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sum_dig != '0, "R8 latency after reset", longint'(sum_dig), 1);
    endtask

    task automatic t_rules();
        // R5 case 1: +1 at position 0 over clear flag
        apply(AW'(2'b01), '0);
        chk(sum_dig == SW'(4'b0111), "R5 pos0 +1", longint'(sum_dig), 7);
        // R1 encoding check on same result: digit0=-1 (11), digit1=+1 (01)
        chk(sum_dig[1:0] == 2'b11 && sum_dig[3:2] == 2'b01, "R1 codes",
            longint'(sum_dig[3:0]), 7);
        // R5 case 2: position 1 pair +1 with flag set
        apply(AW'(4'b0111), '0);
        chk(sum_dig == SW'(6'b000111), "R5 flag set +1", longint'(sum_dig), 7);
        // R5 case 3: position 1 pair -1 with flag set
        apply(AW'(4'b1111), '0);
        chk(sum_dig == SW'(6'b110111), "R5 flag set -1", longint'(sum_dig), 55);
        check_value("R2 directed");
    endtask

    task automatic t_extremes();
        logic [SW-1:0] exp_w;
        apply(fill_word(2'b01), fill_word(2'b01));
        exp_w = '0;
        for (int k = 1; k <= N; k++) exp_w[2*k+:2] = 2'b01;
        chk(sum_dig == exp_w, "R6 all +1", longint'(sum_dig), longint'(exp_w));
        check_value("R2 all +1");
        apply(fill_word(2'b11), fill_word(2'b11));
        exp_w = '0;
        for (int k = 1; k <= N; k++) exp_w[2*k+:2] = 2'b11;
        chk(sum_dig == exp_w, "R6 all -1", longint'(sum_dig), longint'(exp_w));
        check_value("R2 all -1");
        apply(fill_word(2'b01), fill_word(2'b11));
        chk(wval({30'd0, sum_dig}, N + 1) == 0, "R2 +1 vs -1",
            wval({30'd0, sum_dig}, N + 1), 0);
    endtask

    task automatic t_random();
        for (int n = 0; n < 200; n++) begin
            apply(rand_word(), rand_word());
            check_value("R2 random");
        end
    endtask

    task automatic t_locality();
        logic [AW-1:0] a0, b0;
        logic [SW-1:0] ref_s;
        for (int n = 0; n < 20; n++) begin
            a0 = rand_word();
            b0 = rand_word();
            apply(a0, b0);
            ref_s = sum_dig;
            a0[1:0] = (a0[1:0] == 2'b01) ? 2'b11 : 2'b01;
            b0[1:0] = (b0[1:0] == 2'b11) ? 2'b00 : 2'b11;
            apply(a0, b0);
            chk(sum_dig[SW-1:6] == ref_s[SW-1:6], "R4 locality",
                longint'(sum_dig[SW-1:6]), longint'(ref_s[SW-1:6]));
        end
    endtask

    task automatic t_unused_code();
        logic [AW-1:0] a0, b0, a1;
        logic [SW-1:0] ref_s;
        for (int n = 0; n < 10; n++) begin
            a0 = rand_word();
            b0 = rand_word();
            a0[2*(n%N)+:2] = 2'b00;
            apply(a0, b0);
            ref_s = sum_dig;
            a1 = a0;
            a1[2*(n%N)+:2] = 2'b10;
            apply(a1, b0);
            chk(sum_dig == ref_s, "R7 code 10 as zero",
                longint'(sum_dig), longint'(ref_s));
        end
    endtask

    initial begin
        t_reset();
        t_rules();
        t_extremes();
        t_random();
        t_locality();
        t_unused_code();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule